// File: doc/BRIEF.md
# PHY Management Access Controller

This block lets a host processor in a multi-port switch reach the management registers of its PHYs over a two-wire serial management bus (a clock line and a bidirectional data line). The host fills in four 32-bit command words through a small register port: the target port(s), the page, the register number, the clause-45 device and register address, and the write data. It then sets the execute bit and polls that bit until it drops. The controller turns the request into one or more serial frames, captures read data, and flags a read whose PHY never answered.

Two access styles are supported. A paged clause-22 access always sends a page-select write to PHY register 31 and then the target read or write. An MMD access sends a clause-45 address frame and then a clause-45 read or write frame. A write names its targets with a port bitmask, so one command can reach several PHYs in turn. A read names a single port number.

The sequencer states are S_IDLE, S_SETUP, S_ADDR, S_ADDR_WAIT, S_DATA, S_DATA_WAIT, S_ADVANCE and S_FINISH. An accepted execute moves S_IDLE to S_SETUP. S_SETUP goes to S_FINISH when no valid target exists, and to S_ADDR otherwise. S_ADDR launches the page-select or address frame and moves to S_ADDR_WAIT, which stays until the frame ends and then moves to S_DATA. S_DATA launches the target frame and moves to S_DATA_WAIT, which stays until the frame ends and then moves to S_ADVANCE. S_ADVANCE goes back to S_ADDR while ports remain, and to S_FINISH when none are left. S_FINISH always returns to S_IDLE. The bit engine has two states: E_IDLE, and E_SHIFT, entered on a start request and left after the last bit of the frame.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all four command words read zero, the management clock is low and the data line is not driven.
- R2: Word 0 holds a port bitmask in bits NUM_PORTS-1:0. Word 1 holds these fields:
  - bit 0: execute/busy
  - bit 1: MMD select
  - bit 2: write select (0 = read)
  - bits 14:3: page
  - bits 19:15: a stored fill field with no effect
  - bits 24:20: register
  - bit 25: read-only error flag
  Word 2 holds write data or the read port number in bits 31:16, and read data in the read-only bits 15:0. Word 3 holds the MMD device in bits 20:16 and the MMD register in bits 15:0. Unused bits read zero.
- R3: While busy, every host register write is ignored.
- R4: A clause-22 write sends, for each set bit of the mask in ascending port order, a page frame {ST=01, OP=01, PHY=port, REG=31, TA=10, DATA=page zero-extended} followed by {ST=01, OP=01, PHY=port, REG=reg, TA=10, DATA=write data}. Each frame is preceded by 32 preamble ones and sent MSB first.
- R5: A clause-22 read to port p sends the page frame to p and then a read header {ST=01, OP=10, PHY=p, REG=reg}, and places the 16 data bits in word 2 bits 15:0.
- R6: An MMD access sends {ST=00, OP=00, PHY, DEV, TA=10, DATA=MMD register} followed by a frame with OP=01 (write, carrying the write data) or OP=11 (read, data captured into word 2 bits 15:0).
- R7: The error flag is set when the PHY leaves the second turnaround bit of a read high, or when a read names a port number of NUM_PORTS or more; in the second case no frame is sent.
- R8: A write with an all-zero mask completes with no frame sent and no error.
- R9: The controller changes its data output only while the clock is low, releases the line from the first turnaround bit of a read frame, and keeps the clock low and the line released when idle.
- R10: Accepting a new execute clears the error flag left by an earlier command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Command word select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read-back of the selected command word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the controller |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Serial data seen on the line |

## Verification
Several properties are checked on every cycle:
- the bus is quiet whenever the controller is idle;
- the driven data bit stays steady while the clock is high;
- command fields cannot move while a command runs;
- the bit engine is only started when it is idle;
- the error flag can only rise on a read.

The exact content and order of the frames, the ascending walk through a broadcast mask, the page and address pre-frames, the captured read data, and the invalid-port and silent-PHY paths can only be shown by the bench's scenarios against its behavioural PHY.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam logic [1:0] ST_C22      = 2'b01;
    localparam logic [1:0] ST_C45      = 2'b00;
    localparam logic [1:0] OP22_WRITE  = 2'b01;
    localparam logic [1:0] OP22_READ   = 2'b10;
    localparam logic [1:0] OP45_ADDR   = 2'b00;
    localparam logic [1:0] OP45_WRITE  = 2'b01;
    localparam logic [1:0] OP45_READ   = 2'b11;
    localparam logic [4:0] PAGE_REG    = 5'd31;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_ADDR,
        S_ADDR_WAIT,
        S_DATA,
        S_DATA_WAIT,
        S_ADVANCE,
        S_FINISH
    } seq_state_t;

    typedef enum logic {
        E_IDLE,
        E_SHIFT
    } eng_state_t;

    function automatic logic [31:0] build_frame(input logic [1:0] st,
                                                input logic [1:0] op,
                                                input logic [4:0] phy,
                                                input logic [4:0] regad,
                                                input logic [15:0] data);
        return {st, op, phy, regad, 2'b10, data};
    endfunction

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        read_i,
    input  logic [31:0] frame_i,
    input  logic        mdio_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        ta_err_o,
    output logic [15:0] rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o
);
    localparam int TOTAL = PRE_BITS + 32;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam int PW    = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [CW-1:0] PRE_C    = CW'(PRE_BITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(TOTAL - 1);
    localparam logic [PW-1:0] PH_RISE  = PW'(HALF_DIV);
    localparam logic [PW-1:0] PH_LAST  = PW'(2 * HALF_DIV - 1);

    eng_state_t    state_q, state_d;
    logic [31:0]   frame_q;
    logic          read_q;
    logic [CW-1:0] bit_q;
    logic [PW-1:0] ph_q;
    logic [15:0]   rd_q;
    logic          err_q;
    logic          done_q;

    logic          in_frame;
    logic [CW-1:0] fpos;
    logic [4:0]    fidx;

    assign in_frame = (bit_q >= PRE_C);
    assign fpos     = bit_q - PRE_C;
    assign fidx     = fpos[4:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= E_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_IDLE:  if (start_i) state_d = E_SHIFT;
            E_SHIFT: if (ph_q == PH_LAST && bit_q == LAST_BIT) state_d = E_IDLE;
            default: state_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            read_q  <= 1'b0;
            bit_q   <= '0;
            ph_q    <= '0;
            rd_q    <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == E_IDLE) begin
                if (start_i) begin
                    frame_q <= frame_i;
                    read_q  <= read_i;
                    bit_q   <= '0;
                    ph_q    <= '0;
                    rd_q    <= '0;
                    err_q   <= 1'b0;
                end
            end else begin
                if (ph_q == PH_RISE && read_q && in_frame) begin
                    if (fidx == 5'd15 && mdio_i) err_q <= 1'b1;
                    if (fidx >= 5'd16) rd_q <= {rd_q[14:0], mdio_i};
                end
                if (ph_q == PH_LAST) begin
                    ph_q <= '0;
                    if (bit_q == LAST_BIT) done_q <= 1'b1;
                    else                   bit_q  <= bit_q + 1'b1;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q == E_SHIFT);
        done_o    = done_q;
        ta_err_o  = err_q;
        rdata_o   = rd_q;
        mdc_o     = (state_q == E_SHIFT) && (ph_q >= PH_RISE);
        mdio_o    = in_frame ? frame_q[5'd31 - fidx] : 1'b1;
        mdio_oe_o = (state_q == E_SHIFT) && !(read_q && in_frame && fidx >= 5'd14);
    end

endmodule

// File: rtl/mdio_seq_fsm.sv
module mdio_seq_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic                 is_wr_i,
    input  logic                 is_mmd_i,
    input  logic [11:0]          page_i,
    input  logic [4:0]           regad_i,
    input  logic [4:0]           devad_i,
    input  logic [15:0]          mmd_reg_i,
    input  logic [15:0]          hi_field_i,
    input  logic [NUM_PORTS-1:0] mask_i,
    input  logic                 eng_done_i,
    input  logic                 eng_ta_err_i,
    input  logic [15:0]          eng_rdata_i,
    output logic                 busy_o,
    output logic                 eng_start_o,
    output logic                 eng_read_o,
    output logic [31:0]          eng_frame_o,
    output logic                 fin_o,
    output logic                 fin_err_o,
    output logic                 fin_rdv_o,
    output logic [15:0]          fin_rdata_o
);
    seq_state_t           state_q, state_d;
    logic [NUM_PORTS-1:0] remain_q;
    logic                 err_q;
    logic                 rdv_q;
    logic [15:0]          rdata_q;

    logic                 port_ok;
    logic [NUM_PORTS-1:0] init_mask;
    logic [4:0]           cur;
    logic [NUM_PORTS-1:0] cur_bit;
    logic [NUM_PORTS-1:0] rest;
    logic [15:0]          wdata;

    function automatic logic [4:0] lowest_set(input logic [NUM_PORTS-1:0] m);
        logic [4:0] r;
        r = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (m[i]) r = 5'(i);
        end
        return r;
    endfunction

    assign port_ok   = (hi_field_i < 16'(NUM_PORTS));
    assign init_mask = is_wr_i ? mask_i
                     : (port_ok ? (NUM_PORTS'(1) << hi_field_i[4:0]) : '0);
    assign cur       = lowest_set(remain_q);
    assign cur_bit   = NUM_PORTS'(1) << cur;
    assign rest      = remain_q & ~cur_bit;
    assign wdata     = is_wr_i ? hi_field_i : 16'h0000;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (go_i) state_d = S_SETUP;
            S_SETUP:     state_d = (init_mask == '0) ? S_FINISH : S_ADDR;
            S_ADDR:      state_d = S_ADDR_WAIT;
            S_ADDR_WAIT: if (eng_done_i) state_d = S_DATA;
            S_DATA:      state_d = S_DATA_WAIT;
            S_DATA_WAIT: if (eng_done_i) state_d = S_ADVANCE;
            S_ADVANCE:   state_d = (rest == '0) ? S_FINISH : S_ADDR;
            S_FINISH:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            err_q    <= 1'b0;
            rdv_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (state_q == S_SETUP) begin
                remain_q <= init_mask;
                rdv_q    <= 1'b0;
                err_q    <= !is_wr_i && !port_ok;
            end
            if (state_q == S_DATA_WAIT && eng_done_i && !is_wr_i) begin
                rdata_q <= eng_rdata_i;
                rdv_q   <= 1'b1;
                if (eng_ta_err_i) err_q <= 1'b1;
            end
            if (state_q == S_ADVANCE) remain_q <= rest;
        end
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        eng_start_o = (state_q == S_ADDR) || (state_q == S_DATA);
        eng_read_o  = (state_q == S_DATA) && !is_wr_i;
        fin_o       = (state_q == S_FINISH);
        fin_err_o   = err_q;
        fin_rdv_o   = rdv_q;
        fin_rdata_o = rdata_q;
        if (state_q == S_ADDR) begin
            eng_frame_o = is_mmd_i
                ? build_frame(ST_C45, OP45_ADDR, cur, devad_i, mmd_reg_i)
                : build_frame(ST_C22, OP22_WRITE, cur, PAGE_REG, {4'h0, page_i});
        end else begin
            eng_frame_o = is_mmd_i
                ? build_frame(ST_C45, is_wr_i ? OP45_WRITE : OP45_READ, cur, devad_i, wdata)
                : build_frame(ST_C22, is_wr_i ? OP22_WRITE : OP22_READ, cur, regad_i, wdata);
        end
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int PRE_BITS  = 32,
    parameter int HALF_DIV  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [NUM_PORTS-1:0] mask_q;
    logic                 mmd_q;
    logic                 wr_q;
    logic [11:0]          page_q;
    logic [4:0]           fill_q;
    logic [4:0]           reg_q;
    logic                 err_q;
    logic [15:0]          hi_q;
    logic [15:0]          lo_q;
    logic [4:0]           dev_q;
    logic [15:0]          mreg_q;

    logic        seq_busy, wr_ok, go;
    logic        eng_start, eng_read, eng_busy, eng_done, eng_ta_err;
    logic [31:0] eng_frame;
    logic [15:0] eng_rdata, fin_rdata;
    logic        fin, fin_err, fin_rdv;

    assign wr_ok = reg_wr && !seq_busy;
    assign go    = wr_ok && (reg_addr == 2'd1) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            mmd_q  <= 1'b0;
            wr_q   <= 1'b0;
            page_q <= '0;
            fill_q <= '0;
            reg_q  <= '0;
            err_q  <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
            dev_q  <= '0;
            mreg_q <= '0;
        end else begin
            if (wr_ok) begin
                unique case (reg_addr)
                    2'd0: mask_q <= reg_wdata[NUM_PORTS-1:0];
                    2'd1: begin
                        mmd_q  <= reg_wdata[1];
                        wr_q   <= reg_wdata[2];
                        page_q <= reg_wdata[14:3];
                        fill_q <= reg_wdata[19:15];
                        reg_q  <= reg_wdata[24:20];
                    end
                    2'd2: hi_q <= reg_wdata[31:16];
                    2'd3: begin
                        dev_q  <= reg_wdata[20:16];
                        mreg_q <= reg_wdata[15:0];
                    end
                    default: ;
                endcase
            end
            if (go) err_q <= 1'b0;
            else if (fin) err_q <= fin_err;
            if (fin && fin_rdv) lo_q <= fin_rdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            2'd0:    reg_rdata = 32'(mask_q);
            2'd1:    reg_rdata = {6'h00, err_q, reg_q, fill_q, page_q, wr_q, mmd_q, seq_busy};
            2'd2:    reg_rdata = {hi_q, lo_q};
            default: reg_rdata = {11'h000, dev_q, mreg_q};
        endcase
    end

    mdio_seq_fsm #(.NUM_PORTS(NUM_PORTS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .is_wr_i      (wr_q),
        .is_mmd_i     (mmd_q),
        .page_i       (page_q),
        .regad_i      (reg_q),
        .devad_i      (dev_q),
        .mmd_reg_i    (mreg_q),
        .hi_field_i   (hi_q),
        .mask_i       (mask_q),
        .eng_done_i   (eng_done),
        .eng_ta_err_i (eng_ta_err),
        .eng_rdata_i  (eng_rdata),
        .busy_o       (seq_busy),
        .eng_start_o  (eng_start),
        .eng_read_o   (eng_read),
        .eng_frame_o  (eng_frame),
        .fin_o        (fin),
        .fin_err_o    (fin_err),
        .fin_rdv_o    (fin_rdv),
        .fin_rdata_o  (fin_rdata)
    );

    mdio_frame_engine #(.PRE_BITS(PRE_BITS), .HALF_DIV(HALF_DIV)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (eng_start),
        .read_i    (eng_read),
        .frame_i   (eng_frame),
        .mdio_i    (mdio_i),
        .busy_o    (eng_busy),
        .done_o    (eng_done),
        .ta_err_o  (eng_ta_err),
        .rdata_o   (eng_rdata),
        .mdc_o     (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
    parameter int NUM_PORTS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mdc,
    input logic                 mdio_o,
    input logic                 mdio_oe,
    input logic                 busy,
    input logic                 eng_start,
    input logic                 eng_busy,
    input logic                 err_q,
    input logic                 wr_q,
    input logic [NUM_PORTS-1:0] mask_q,
    input logic [11:0]          page_q,
    input logic [15:0]          hi_q
);
    assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_steady_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc) && mdio_oe && $past(mdio_oe)) |-> $stable(mdio_o));

    assert_frozen_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({mask_q, page_q, hi_q}));

    assert_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);

    assert_err_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !wr_q);

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (seq_busy),
    .eng_start (eng_start),
    .eng_busy  (eng_busy),
    .err_q     (err_q),
    .wr_q      (wr_q),
    .mask_q    (mask_q),
    .page_q    (page_q),
    .hi_q      (hi_q)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_oe = 1'b0, phy_d = 1'b1;
    logic        bus;

    int n_total = 0, n_fail = 0;
    bit finished = 1'b0;

    assign bus    = mdio_oe ? mdio_o : (phy_oe ? phy_d : 1'b1);
    assign mdio_i = bus;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // behavioural PHY on the shared line
    int          ones = 0, pos = 0, conflicts = 0, log_n = 0;
    bit          in_fr = 1'b0, rd_act = 1'b0, ta_fault = 1'b0;
    logic [31:0] sh = 32'h0;
    logic [15:0] mmd_addr = 16'h0, rd_word = 16'h0;
    logic [31:0] log_f [0:63];

    function automatic logic [15:0] c22_val(input logic [4:0] p, input logic [4:0] r);
        return {3'b000, p, 3'b000, r} ^ 16'h5A00;
    endfunction

    function automatic logic [31:0] fr(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] p, input logic [4:0] r,
                                       input logic [15:0] d);
        return {st, op, p, r, 2'b10, d};
    endfunction

    function automatic logic [31:0] w1(input logic [4:0] r, input logic [11:0] pg,
                                       input bit wr, input bit mmd);
        return {7'h00, r, 5'h1F, pg, wr, mmd, 1'b1};
    endfunction

    always @(posedge mdc) begin
        if (mdio_oe && phy_oe) conflicts++;
        if (!in_fr) begin
            if (bus) begin
                if (ones < 1000) ones++;
            end else if (ones >= 32) begin
                in_fr = 1'b1; pos = 1; sh = 32'h0; ones = 0;
            end else begin
                ones = 0;
            end
        end else begin
            sh = {sh[30:0], bus};
            pos++;
            if (pos == 14) begin
                rd_act  = (sh[13:12] == 2'b01 && sh[11:10] == 2'b10) ||
                          (sh[13:12] == 2'b00 && sh[11:10] == 2'b11);
                rd_word = (sh[13:12] == 2'b01) ? c22_val(sh[9:5], sh[4:0])
                                               : (mmd_addr ^ 16'h3C3C);
            end
            if (pos == 32) begin
                if (log_n < 64) log_f[log_n] = sh;
                log_n++;
                if (sh[31:28] == 4'b0000) mmd_addr = sh[15:0];
                in_fr = 1'b0; rd_act = 1'b0;
            end
        end
    end

    always @(negedge mdc) begin
        if (in_fr && rd_act && pos >= 15 && !ta_fault) begin
            phy_oe = 1'b1;
            phy_d  = (pos == 15) ? 1'b0 : rd_word[31-pos];
        end else begin
            phy_oe = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_frame(input string req, input int idx, input logic [31:0] exp, input bit hdr);
        logic [31:0] a;
        a = (idx < 64) ? log_f[idx] : 32'hX;
        if (hdr) check(req, {18'h0, a[31:18]}, {18'h0, exp[31:18]});
        else     check(req, a, exp);
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int guard;
        guard = 0;
        do begin
            host_rd(2'd1, v);
            guard++;
        end while (v[0] && guard < 20000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            host_rd(2'(a), v);
            check("R1 reset word", v, 32'h0);
        end
        check("R1 idle clock/oe", {30'h0, mdc, mdio_oe}, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        host_wr(2'd1, 32'hFFFF_FFFE);
        host_rd(2'd1, v); check("R2 word1 fields", v, 32'h01FF_FFFE);
        host_wr(2'd3, 32'hFFFF_FFFF);
        host_rd(2'd3, v); check("R2 word3 fields", v, 32'h001F_FFFF);
        host_wr(2'd0, 32'hFFFF_FFFF);
        host_rd(2'd0, v); check("R2 word0 mask", v, 32'h0000_00FF);
        host_wr(2'd2, 32'hFFFF_FFFF);
        host_rd(2'd2, v); check("R2 word2 low read-only", v, 32'hFFFF_0000);
    endtask

    task automatic t_c22_bcast_write();
        logic [31:0] v;
        int base, k;
        int ports [3] = '{2, 5, 7};
        base = log_n;
        host_wr(2'd0, 32'h0000_00A4);
        host_wr(2'd2, 32'hBEEF_0000);
        host_wr(2'd1, w1(5'd9, 12'h123, 1'b1, 1'b0));
        host_rd(2'd1, v); check("R2 busy set", {31'h0, v[0]}, 32'h1);
        host_wr(2'd2, 32'hDEAD_0000);
        host_wr(2'd0, 32'h0000_0001);
        wait_idle();
        host_rd(2'd2, v); check("R3 word2 kept", v[31:16], 32'h0000_BEEF);
        host_rd(2'd0, v); check("R3 mask kept", v, 32'h0000_00A4);
        host_rd(2'd1, v); check("R4 err clear", {31'h0, v[25]}, 32'h0);
        check("R4 frame count", log_n - base, 6);
        k = base;
        foreach (ports[i]) begin
            check_frame("R4 page frame", k, fr(2'b01, 2'b01, 5'(ports[i]), 5'd31, 16'h0123), 1'b0);
            check_frame("R4 write frame", k + 1, fr(2'b01, 2'b01, 5'(ports[i]), 5'd9, 16'hBEEF), 1'b0);
            k += 2;
        end
        check("R9 no contention", conflicts, 0);
    endtask

    task automatic t_c22_read();
        logic [31:0] v;
        int base;
        base = log_n;
        host_wr(2'd2, 32'h0006_0000);
        host_wr(2'd1, w1(5'd3, 12'h007, 1'b0, 1'b0));
        wait_idle();
        check("R5 frame count", log_n - base, 2);
        check_frame("R5 page frame", base, fr(2'b01, 2'b01, 5'd6, 5'd31, 16'h0007), 1'b0);
        check_frame("R5 read header", base + 1, fr(2'b01, 2'b10, 5'd6, 5'd3, 16'h0), 1'b1);
        host_rd(2'd2, v); check("R5 read data", v, {16'h0006, c22_val(5'd6, 5'd3)});
        host_rd(2'd1, v); check("R5 no error", {31'h0, v[25]}, 32'h0);
        check("R9 no contention on read", conflicts, 0);
        check("R9 idle after read", {30'h0, mdc, mdio_oe}, 32'h0);
    endtask

    task automatic t_ta_fault();
        logic [31:0] v;
        ta_fault = 1'b1;
        host_wr(2'd2, 32'h0001_0000);
        host_wr(2'd1, w1(5'd2, 12'h000, 1'b0, 1'b0));
        wait_idle();
        ta_fault = 1'b0;
        host_rd(2'd1, v); check("R7 silent PHY error", {31'h0, v[25]}, 32'h1);
    endtask

    task automatic t_new_cmd_clears();
        logic [31:0] v;
        host_wr(2'd0, 32'h0000_0001);
        host_wr(2'd2, 32'h1111_0000);
        host_wr(2'd1, w1(5'd4, 12'h000, 1'b1, 1'b0));
        wait_idle();
        host_rd(2'd1, v); check("R10 error cleared", {31'h0, v[25]}, 32'h0);
    endtask

    task automatic t_bad_port();
        logic [31:0] v;
        int base;
        base = log_n;
        host_wr(2'd2, 32'h0009_0000);
        host_wr(2'd1, w1(5'd1, 12'h000, 1'b0, 1'b0));
        wait_idle();
        host_rd(2'd1, v); check("R7 invalid port error", {31'h0, v[25]}, 32'h1);
        check("R7 invalid port no frame", log_n - base, 0);
    endtask

    task automatic t_empty_mask();
        logic [31:0] v;
        int base;
        base = log_n;
        host_wr(2'd0, 32'h0);
        host_wr(2'd1, w1(5'd1, 12'h000, 1'b1, 1'b0));
        wait_idle();
        host_rd(2'd1, v);
        check("R8 empty mask idle", {31'h0, v[0]}, 32'h0);
        check("R8 empty mask no error", {31'h0, v[25]}, 32'h0);
        check("R8 empty mask no frame", log_n - base, 0);
    endtask

    task automatic t_mmd_write();
        int base;
        base = log_n;
        host_wr(2'd0, 32'h0000_000A);
        host_wr(2'd2, 32'h5555_0000);
        host_wr(2'd3, 32'h0005_1234);
        host_wr(2'd1, w1(5'd0, 12'h000, 1'b1, 1'b1));
        wait_idle();
        check("R6 mmd write count", log_n - base, 4);
        check_frame("R6 addr frame p1", base,     fr(2'b00, 2'b00, 5'd1, 5'd5, 16'h1234), 1'b0);
        check_frame("R6 write frame p1", base + 1, fr(2'b00, 2'b01, 5'd1, 5'd5, 16'h5555), 1'b0);
        check_frame("R6 addr frame p3", base + 2, fr(2'b00, 2'b00, 5'd3, 5'd5, 16'h1234), 1'b0);
        check_frame("R6 write frame p3", base + 3, fr(2'b00, 2'b01, 5'd3, 5'd5, 16'h5555), 1'b0);
    endtask

    task automatic t_mmd_read();
        logic [31:0] v;
        int base;
        base = log_n;
        host_wr(2'd2, 32'h0004_0000);
        host_wr(2'd3, 32'h001E_ABCD);
        host_wr(2'd1, w1(5'd0, 12'h000, 1'b0, 1'b1));
        wait_idle();
        check("R6 mmd read count", log_n - base, 2);
        check_frame("R6 mmd addr frame", base, fr(2'b00, 2'b00, 5'd4, 5'd30, 16'hABCD), 1'b0);
        check_frame("R6 mmd read header", base + 1, fr(2'b00, 2'b11, 5'd4, 5'd30, 16'h0), 1'b1);
        host_rd(2'd2, v); check("R6 mmd read data", v, {16'h0004, 16'hABCD ^ 16'h3C3C});
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_layout();
        t_c22_bcast_write();
        t_c22_read();
        t_ta_fault();
        t_new_cmd_clears();
        t_bad_port();
        t_empty_mask();
        t_mmd_write();
        t_mmd_read();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule